// File: doc/BRIEF.md
# Test-and-Set-Bits Read-Modify-Write Sequencer

This block carries out a test-and-set-bits instruction on a byte-wide memory bus, one bus cycle per clock. A start pulse brings in the opcode byte, the program counter of that opcode, the accumulator, an accumulator-width flag and the 16-bit direct page register. The block then fetches the opcode and the address operand bytes, reads the memory operand and spends one internal cycle. It then writes back the operand with every accumulator bit that is 1 forced to 1. It also sets or clears the zero flag from the AND of the accumulator and the original operand. That AND value is not kept anywhere else. No other status flag is driven.

Two addressing modes are supported. In absolute mode the two bytes after the opcode form the address. In direct page mode the one byte after the opcode is added to the direct page register, and the sum wraps at 2^16. With a 16-bit accumulator each access becomes two bytes. A direct page register whose low byte is not zero costs one extra idle cycle. All other opcodes are refused.

Top module: `bitset_rmw_unit`

## Requirements
- R1: A start pulse is taken only while the unit is idle and only when the opcode is 0x0C (absolute) or 0x04 (direct page). Any other start is ignored: no strobe, busy stays low, and the zero flag keeps its value.
- R2: Busy is high for exactly the following number of cycles, starting in the cycle after the accepted start. Absolute mode takes 6 cycles with an 8-bit accumulator and 8 with a 16-bit one. Direct page mode takes 5 or 7, plus 1 when the low byte of the direct page register is not zero.
- R3: The first cycle reads at the program counter. The next cycle reads at program counter + 1. In absolute mode a further cycle reads at program counter + 2, and that byte is the high address byte.
- R4: Each written byte equals the byte read earlier from the same address, ORed with the matching accumulator byte (the low accumulator byte for the lower address, the high byte for address + 1).
- R5: In the cycle that done is high, the zero flag is 1 exactly when the AND of the accumulator and the original operand is zero. For an 8-bit accumulator only the low byte counts. At all other times the flag holds its value.
- R6: Read and write strobes are never both high. Neither strobe is high in the internal cycle or the direct page penalty cycle.
- R7: Done is a one-cycle pulse in the cycle after the final write, with busy low in that cycle.
- R8: The direct page address is the direct page register plus the zero-extended offset byte, modulo 2^16.
- R9: With a 16-bit accumulator the operand is read at the address and then at address + 1. After the internal cycle it is written at address + 1 first and at the address last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for one instruction |
| opcode | input | 8 | Opcode byte, selects the addressing mode |
| pcIn | input | 16 | Address of the opcode byte |
| accIn | input | 16 | Accumulator value |
| accWide | input | 1 | 1 selects a 16-bit accumulator |
| dirPage | input | 16 | Direct page register |
| busAddr | output | 16 | Memory bus address |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data, sampled at the end of a read cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| zeroFlag | output | 1 | Zero flag |

## Verification
A start request can arrive in the same cycle as an instruction that is already running. The bench raises start with a valid direct page opcode in the middle of an absolute, 16-bit run. The reference model's cycle list is kept as if that request had never been made, so any extra strobe, address change or added busy cycle shows up as a miscompare. The zero-flag update also lands in the same cycle as the done pulse. That cycle is compared for both the flag value and the pulse. The flag is checked again after a refused start, to confirm it held its value.

// File: rtl/bitset_pkg.sv
package bitset_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_OFF_LO, ST_OFF_HI, ST_DP_PEN,
    ST_RD_LO, ST_RD_HI, ST_INTERNAL, ST_WR_HI, ST_WR_LO
  } seqState_t;

  typedef enum logic [2:0] {
    AS_PC0, AS_PC1, AS_PC2, AS_EA, AS_EA1
  } addrSel_t;

  typedef struct packed {
    logic     load;
    logic     capOffLo;
    logic     capOffHi;
    logic     capMemLo;
    logic     capMemHi;
    logic     rd;
    logic     wr;
    logic     hiByte;
    logic     updZ;
    logic     dpMode;
    logic     wide;
    addrSel_t addrSel;
  } ctlBus_t;

endpackage

// File: rtl/bitset_ctl.sv
module bitset_ctl
  import bitset_pkg::*;
#(
  parameter logic [7:0] OPC_ABS = 8'h0C,
  parameter logic [7:0] OPC_DP  = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic       accWide,
  input  logic       dpLowNz,
  output ctlBus_t    ctl,
  output logic       busy,
  output logic       done
);

  seqState_t state, nextState;
  logic modeDp, modeWide, modePen;
  logic accept;

  assign accept = (state == ST_IDLE) && start &&
                  ((opcode == OPC_ABS) || (opcode == OPC_DP));

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:     if (accept) nextState = ST_OPC;
      ST_OPC:      nextState = ST_OFF_LO;
      ST_OFF_LO:   nextState = !modeDp ? ST_OFF_HI : (modePen ? ST_DP_PEN : ST_RD_LO);
      ST_OFF_HI:   nextState = ST_RD_LO;
      ST_DP_PEN:   nextState = ST_RD_LO;
      ST_RD_LO:    nextState = modeWide ? ST_RD_HI : ST_INTERNAL;
      ST_RD_HI:    nextState = ST_INTERNAL;
      ST_INTERNAL: nextState = modeWide ? ST_WR_HI : ST_WR_LO;
      ST_WR_HI:    nextState = ST_WR_LO;
      ST_WR_LO:    nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      modeDp   <= 1'b0;
      modeWide <= 1'b0;
      modePen  <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (state == ST_WR_LO);
      if (accept) begin
        modeDp   <= (opcode == OPC_DP);
        modeWide <= accWide;
        modePen  <= (opcode == OPC_DP) && dpLowNz;
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.load     = accept;
    ctl.dpMode   = modeDp;
    ctl.wide     = modeWide;
    ctl.addrSel  = AS_PC0;
    case (state)
      ST_OPC:    ctl.rd = 1'b1;
      ST_OFF_LO: begin ctl.rd = 1'b1; ctl.addrSel = AS_PC1; ctl.capOffLo = 1'b1; end
      ST_OFF_HI: begin ctl.rd = 1'b1; ctl.addrSel = AS_PC2; ctl.capOffHi = 1'b1; end
      ST_RD_LO:  begin ctl.rd = 1'b1; ctl.addrSel = AS_EA;  ctl.capMemLo = 1'b1; end
      ST_RD_HI:  begin ctl.rd = 1'b1; ctl.addrSel = AS_EA1; ctl.capMemHi = 1'b1; ctl.hiByte = 1'b1; end
      ST_WR_HI:  begin ctl.wr = 1'b1; ctl.addrSel = AS_EA1; ctl.hiByte = 1'b1; end
      ST_WR_LO:  begin ctl.wr = 1'b1; ctl.addrSel = AS_EA;  ctl.updZ = 1'b1; end
      default:   ;
    endcase
  end

  assign busy = (state != ST_IDLE);

  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.rd && ctl.wr));

  a_r6_quiet_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTERNAL || state == ST_DP_PEN) |-> (!ctl.rd && !ctl.wr));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ctl.wr) && !busy));

  a_r9_low_write_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wr && !ctl.hiByte && ctl.wide) |-> $past(ctl.wr && ctl.hiByte));

  a_r1_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !ctl.load);

endmodule

// File: rtl/bitset_dp.sv
module bitset_dp
  import bitset_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctlBus_t               ctl,
  input  logic [2*BYTE_W-1:0]   pcIn,
  input  logic [2*BYTE_W-1:0]   accIn,
  input  logic [2*BYTE_W-1:0]   dirPage,
  input  logic [BYTE_W-1:0]     busRdata,
  output logic [2*BYTE_W-1:0]   busAddr,
  output logic [BYTE_W-1:0]     busWdata,
  output logic                  zeroFlag
);

  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] pcR, accR, dpR, effAddr;
  logic [BYTE_W-1:0] offLo, offHi, memLo, memHi;
  logic [ADDR_W-1:0] rdAddrLo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcR      <= '0;
      accR     <= '0;
      dpR      <= '0;
      offLo    <= '0;
      offHi    <= '0;
      memLo    <= '0;
      memHi    <= '0;
      zeroFlag <= 1'b0;
      rdAddrLo <= '0;
    end else begin
      if (ctl.load) begin
        pcR  <= pcIn;
        accR <= accIn;
        dpR  <= dirPage;
      end
      if (ctl.capOffLo) offLo <= busRdata;
      if (ctl.capOffHi) offHi <= busRdata;
      if (ctl.capMemLo) begin
        memLo    <= busRdata;
        rdAddrLo <= busAddr;
      end
      if (ctl.capMemHi) memHi <= busRdata;
      if (ctl.updZ) begin
        if (ctl.wide) zeroFlag <= (({memHi, memLo} & accR) == '0);
        else          zeroFlag <= ((memLo & accR[BYTE_W-1:0]) == '0);
      end
    end
  end

  assign effAddr = ctl.dpMode ? (dpR + ADDR_W'(offLo)) : {offHi, offLo};

  always_comb begin
    case (ctl.addrSel)
      AS_PC0:  busAddr = pcR;
      AS_PC1:  busAddr = pcR + ADDR_W'(1);
      AS_PC2:  busAddr = pcR + ADDR_W'(2);
      AS_EA:   busAddr = effAddr;
      AS_EA1:  busAddr = effAddr + ADDR_W'(1);
      default: busAddr = pcR;
    endcase
  end

  assign busWdata = ctl.hiByte ? (memHi | accR[ADDR_W-1:BYTE_W])
                               : (memLo | accR[BYTE_W-1:0]);

  a_r4_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wr && !ctl.hiByte) |-> (busAddr == rdAddrLo));

  a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.updZ |=> $stable(zeroFlag));

endmodule

// File: rtl/bitset_rmw_unit.sv
module bitset_rmw_unit
  import bitset_pkg::*;
#(
  parameter int         BYTE_W  = 8,
  parameter logic [7:0] OPC_ABS = 8'h0C,
  parameter logic [7:0] OPC_DP  = 8'h04
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          opcode,
  input  logic [2*BYTE_W-1:0] pcIn,
  input  logic [2*BYTE_W-1:0] accIn,
  input  logic                accWide,
  input  logic [2*BYTE_W-1:0] dirPage,
  output logic [2*BYTE_W-1:0] busAddr,
  output logic                busRd,
  output logic                busWr,
  output logic [BYTE_W-1:0]   busWdata,
  input  logic [BYTE_W-1:0]   busRdata,
  output logic                busy,
  output logic                done,
  output logic                zeroFlag
);

  ctlBus_t ctl;

  bitset_ctl #(.OPC_ABS(OPC_ABS), .OPC_DP(OPC_DP)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opcode  (opcode),
    .accWide (accWide),
    .dpLowNz (dirPage[BYTE_W-1:0] != '0),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  bitset_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .pcIn     (pcIn),
    .accIn    (accIn),
    .dirPage  (dirPage),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .zeroFlag (zeroFlag)
  );

  assign busRd = ctl.rd;
  assign busWr = ctl.wr;

endmodule

// File: tb/sim_bitset_rmw_unit.sv
module sim_bitset_rmw_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pcIn = '0, accIn = '0, dirPage = '0;
  logic        accWide = 1'b0;
  logic [15:0] busAddr;
  logic        busRd, busWr, busy, done, zeroFlag;
  logic [7:0]  busWdata, busRdata;
  logic [7:0]  seed = 8'h00;

  int vecs = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wd;
  } cyc_t;

  cyc_t expQ[$];

  always #4 clk = ~clk;

  assign busRdata = busAddr[7:0] ^ {busAddr[14:8], busAddr[15]} ^ seed;

  bitset_rmw_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pcIn(pcIn),
    .accIn(accIn), .accWide(accWide), .dirPage(dirPage), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .busy(busy), .done(done), .zeroFlag(zeroFlag)
  );

  function automatic logic [7:0] memAt(logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ seed;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    vecs++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(logic rd, logic wr, logic [15:0] a, logic [7:0] wd);
    cyc_t c;
    c.rd = rd; c.wr = wr; c.addr = a; c.wd = wd;
    expQ.push_back(c);
  endtask

  // Runs one instruction; pokeAt > 0 raises a second start in that busy cycle.
  task automatic runInstr(logic [7:0] op, logic [15:0] pc, logic [15:0] acc,
                          logic wide, logic [15:0] dp, logic [7:0] sd, int pokeAt);
    logic [15:0] ea;
    logic [7:0]  ml, mh;
    logic        zExp;
    int          n;
    @(negedge clk);
    seed = sd;
    expQ.delete();
    push(1, 0, pc, 0);
    push(1, 0, pc + 16'd1, 0);
    if (op == 8'h0C) begin
      push(1, 0, pc + 16'd2, 0);
      ea = {memAt(pc + 16'd2), memAt(pc + 16'd1)};
    end else begin
      if (dp[7:0] != 8'h00) push(0, 0, 16'h0, 0);
      ea = dp + {8'h00, memAt(pc + 16'd1)};
    end
    ml = memAt(ea);
    mh = memAt(ea + 16'd1);
    push(1, 0, ea, 0);
    if (wide) push(1, 0, ea + 16'd1, 0);
    push(0, 0, 16'h0, 0);
    if (wide) push(0, 1, ea + 16'd1, mh | acc[15:8]);
    push(0, 1, ea, ml | acc[7:0]);
    zExp = wide ? (({mh, ml} & acc) == 16'h0) : ((ml & acc[7:0]) == 8'h0);
    n = expQ.size();
    start = 1; opcode = op; pcIn = pc; accIn = acc; accWide = wide; dirPage = dp;
    for (int i = 0; i < n; i++) begin
      cyc_t c;
      @(negedge clk);
      start = 0;
      if (pokeAt == i) begin start = 1; opcode = 8'h04; pcIn = 16'h0100; end
      c = expQ[i];
      chk("R2", "busy", busy, 1);
      chk("R6", "rd", busRd, c.rd);
      chk("R6", "wr", busWr, c.wr);
      chk("R7", "done early", done, 0);
      if (c.rd || c.wr) chk((i < 3) ? "R3" : "R9", "addr", busAddr, c.addr);
      if (c.wr) chk("R4", "wdata", busWdata, c.wd);
    end
    @(negedge clk);
    start = 0;
    chk("R7", "done", done, 1);
    chk("R7", "busy at done", busy, 0);
    chk("R5", "zero", zeroFlag, zExp);
    chk("R6", "no strobe at done", busRd | busWr, 0);
    @(negedge clk);
    chk("R7", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic zKeep;
    repeat (3) @(negedge clk);
    chk("R7", "reset busy", busy, 0);
    chk("R6", "reset strobes", busRd | busWr, 0);
    chk("R7", "reset done", done, 0);
    chk("R5", "reset zero", zeroFlag, 0);
    rst_n = 1;

    runInstr(8'h0C, 16'h1000, 16'h0081, 0, 16'h0000, 8'h5A, -1); // R3 abs, 6 cycles
    runInstr(8'h0C, 16'h2222, 16'hF00F, 1, 16'h0000, 8'h13, -1); // R9 abs wide, 8 cycles
    runInstr(8'h04, 16'h3000, 16'h0000, 0, 16'h4400, 8'h77, -1); // R5 acc zero -> Z set, 5 cycles
    runInstr(8'h04, 16'h3000, 16'h00FF, 0, 16'h4412, 8'h77, -1); // R2 penalty, 6 cycles
    runInstr(8'h04, 16'h0500, 16'hFFFF, 1, 16'h8001, 8'h3C, -1); // R9 dp wide + penalty, 8
    runInstr(8'h04, 16'h2040, 16'h0010, 0, 16'hFFF8, 8'h80, -1); // R8 wrap
    runInstr(8'h0C, 16'h6000, 16'h1234, 1, 16'h0000, 8'hA5, 3);  // R1 start while busy

    zKeep = zeroFlag;
    @(negedge clk);
    start = 1; opcode = 8'hEA; pcIn = 16'h0700;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R1", "bad opcode busy", busy, 0);
      chk("R1", "bad opcode strobes", busRd | busWr, 0);
      chk("R1", "bad opcode zero", zeroFlag, zKeep);
      @(negedge clk);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule